// File: doc/BRIEF.md
# PLL Divider Word Calculator

This block converts between a wanted PLL output frequency and the settings that produce it. In forward mode it takes a requested frequency and a reference frequency, both unsigned integers in Hz. It returns a power-of-two post-divider code and a fixed-point feedback divider word. In reverse mode it takes a stored divider word and post-divider code and returns the output frequency those settings give.

Both modes run on one shared restoring divider that yields one quotient bit per clock. A one-cycle `start_i` launches an operation and a one-cycle `done_o` ends it. Parameters set the word width and the split between integer and fraction bits. The minimum and maximum VCO frequencies are also parameters.

Top module: `pll_word_calc`

## Requirements
- R1: The divider word is WORD_W bits wide. Its upper INT_BITS bits are the integer part and the lower FRAC_W = WORD_W - INT_BITS bits are the fraction, so the word represents the feedback ratio times 2^FRAC_W.
- R2: In forward mode, a requested frequency above FMAX_HZ is replaced by FMAX_HZ before the post-divider and the word are computed.
- R3: In forward mode the post-divider exponent k is the smallest value in 0..4 for which the clamped frequency times 2^k is at least FMIN_HZ. If no value qualifies, k is 4. `code_o` reports k as a 3-bit binary value.
- R4: In forward mode `word_o` = floor((clamped frequency * 2^k * 2^FRAC_W) / reference), keeping only the low WORD_W bits.
- R5: In reverse mode the VCO frequency is reference * `word_i` shifted right by FRAC_W. It is raised by one when any of the shifted-out bits were nonzero.
- R6: In reverse mode the 3-bit `code_i` selects a divide ratio of 2^code (code 0..7). `rate_o` = ceil(VCO / 2^code).
- R7: `done_o` rises DIV_W+1 clock edges after the edge that accepts `start_i`, where DIV_W = max(FREQ_W+4+FRAC_W, FREQ_W+INT_BITS+2). A `start_i` seen while an operation is running is ignored and does not change its result or timing.
- R8: A start with a zero reference frequency does not run the divider. It sets `error_o` and pulses `done_o` on the same edge that accepts it, and leaves the result outputs unchanged. The next accepted start with a nonzero reference clears `error_o`.
- R9: `done_o` is high for one cycle only. Result outputs change only on the edge that raises `done_o`, and then hold. A forward operation leaves `rate_o` unchanged, and a reverse operation leaves `word_o` and `code_o` unchanged.
- R10: After reset, `done_o`, `error_o`, `word_o`, `code_o` and `rate_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch an operation (accepted when idle) |
| rev_mode_i | input | 1 | 0: frequency to settings, 1: settings to frequency |
| freq_req_i | input | FREQ_W | Requested output frequency in Hz (forward) |
| ref_freq_i | input | FREQ_W | Reference frequency in Hz |
| word_i | input | WORD_W | Stored divider word (reverse) |
| code_i | input | 3 | Stored post-divider exponent (reverse) |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Last start had a zero reference |
| word_o | output | WORD_W | Computed divider word |
| code_o | output | 3 | Computed post-divider exponent |
| rate_o | output | FREQ_W+INT_BITS+1 | Computed output frequency in Hz |

## Verification
A normal operation finishes DIV_W+1 edges after the edge that takes `start_i`: DIV_W edges for the divider, then one edge to register the result. A zero-reference start finishes on the accepting edge itself. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge until `done_o` appears, and compares that count with DIV_W+2 (or 1 on the error path) before it reads any result. One cycle later it confirms that `done_o` has dropped and that the results still hold.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic {
        MODE_FWD = 1'b0,
        MODE_REV = 1'b1
    } calc_mode_e;

    localparam int CODE_W = 3;
    localparam int K_MAX  = 4;

endpackage

// File: rtl/pll_postdiv_sel.sv
module pll_postdiv_sel #(
    parameter int          FREQ_W  = 32,
    parameter int          K_MAX   = 4,
    parameter int          CODE_W  = 3,
    parameter logic [63:0] FMIN_HZ = 64'd1_000_000_000,
    parameter logic [63:0] FMAX_HZ = 64'd3_800_000_000
) (
    input  logic [FREQ_W-1:0] freq_in,
    output logic [FREQ_W-1:0] freq_clamped,
    output logic [CODE_W-1:0] k_sel
);

    logic [K_MAX:0] meets;

    // Clamp against the configured ceiling first.
    assign freq_clamped = (64'(freq_in) > FMAX_HZ) ? FREQ_W'(FMAX_HZ) : freq_in;

    // One comparator per candidate exponent.
    for (genvar i = 0; i <= K_MAX; i++) begin : g_cand
        assign meets[i] = ((64'(freq_clamped) << i) >= FMIN_HZ);
    end

    // Lowest qualifying exponent wins; default to the largest.
    always_comb begin
        k_sel = CODE_W'(K_MAX);
        for (int i = K_MAX; i >= 0; i--) begin
            if (meets[i]) k_sel = CODE_W'(i);
        end
    end

endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
    parameter int NUM_W = 51,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [NUM_W-1:0] quo;
        logic             fin;
    } div_regs_t;

    div_regs_t q, d;
    logic [DEN_W:0] trial;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        trial = {q.rem, q.quo[NUM_W-1]};
        if (load) begin
            d.cnt = CNT_W'(NUM_W);
            d.rem = '0;
            d.den = den;
            d.quo = num;
        end else if (q.cnt != '0) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = DEN_W'(trial - {1'b0, q.den});
                d.quo = {q.quo[NUM_W-2:0], 1'b1};
            end else begin
                d.rem = trial[DEN_W-1:0];
                d.quo = {q.quo[NUM_W-2:0], 1'b0};
            end
            d.cnt = q.cnt - CNT_W'(1);
            d.fin = (q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin = q.fin;
    assign quo = q.quo;

    // R4: partial remainder stays below the divisor during every step
    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0) |-> (q.rem < q.den));

    // R7: a running division advances exactly one bit per cycle
    assert_step_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0 && !load) |=> (q.cnt == $past(q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/pll_word_calc.sv
module pll_word_calc
    import pll_calc_pkg::*;
#(
    parameter int          FREQ_W   = 32,
    parameter int          WORD_W   = 22,
    parameter int          INT_BITS = 7,
    parameter logic [63:0] FMIN_HZ  = 64'd1_000_000_000,
    parameter logic [63:0] FMAX_HZ  = 64'd3_800_000_000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        rev_mode_i,
    input  logic [FREQ_W-1:0]           freq_req_i,
    input  logic [FREQ_W-1:0]           ref_freq_i,
    input  logic [WORD_W-1:0]           word_i,
    input  logic [CODE_W-1:0]           code_i,
    output logic                        done_o,
    output logic                        error_o,
    output logic [WORD_W-1:0]           word_o,
    output logic [CODE_W-1:0]           code_o,
    output logic [FREQ_W+INT_BITS:0]    rate_o
);

    localparam int FRAC_W = WORD_W - INT_BITS;
    localparam int RATE_W = FREQ_W + INT_BITS + 1;
    localparam int NUM_W  = FREQ_W + K_MAX + FRAC_W;
    localparam int VCO_W  = FREQ_W + WORD_W;
    localparam int DIV_W  = (NUM_W > RATE_W + 1) ? NUM_W : RATE_W + 1;

    typedef struct packed {
        run_state_e          st;
        calc_mode_e          mode;
        logic [CODE_W-1:0]   k_pend;
        logic [CODE_W-1:0]   code;
        logic [WORD_W-1:0]   word;
        logic [RATE_W-1:0]   rate;
        logic                done;
        logic                err;
    } top_regs_t;

    top_regs_t q, d;

    // Forward path operands
    logic [FREQ_W-1:0] fclamp;
    logic [CODE_W-1:0] ksel;
    logic [DIV_W-1:0]  fwd_num;

    // Reverse path operands
    logic [VCO_W-1:0]  vco;
    logic              sticky;
    logic [RATE_W-1:0] vco_int;
    logic [FREQ_W-1:0] pdiv;
    logic [DIV_W-1:0]  rev_num;

    // Divider handshake
    logic              div_load;
    logic [DIV_W-1:0]  div_num;
    logic [FREQ_W-1:0] div_den;
    logic              div_fin;
    logic [DIV_W-1:0]  div_quo;
    logic              unused_quo_bits;
    logic              accept;

    pll_postdiv_sel #(
        .FREQ_W (FREQ_W),
        .K_MAX  (K_MAX),
        .CODE_W (CODE_W),
        .FMIN_HZ(FMIN_HZ),
        .FMAX_HZ(FMAX_HZ)
    ) u_sel (
        .freq_in     (freq_req_i),
        .freq_clamped(fclamp),
        .k_sel       (ksel)
    );

    assign fwd_num = DIV_W'(fclamp) << (int'(ksel) + FRAC_W);

    assign vco = VCO_W'(ref_freq_i) * VCO_W'(word_i);

    if (FRAC_W > 0) begin : g_frac
        assign sticky = |vco[FRAC_W-1:0];
    end else begin : g_nofrac
        assign sticky = 1'b0;
    end

    assign vco_int = RATE_W'(vco >> FRAC_W) + RATE_W'(sticky);
    assign pdiv    = FREQ_W'(1) << code_i;
    assign rev_num = DIV_W'(vco_int) + DIV_W'(pdiv) - DIV_W'(1);

    assign accept  = (q.st == ST_IDLE) && start_i;
    assign div_num = rev_mode_i ? rev_num : fwd_num;
    assign div_den = rev_mode_i ? pdiv : ref_freq_i;

    pll_restoring_div #(
        .NUM_W(DIV_W),
        .DEN_W(FREQ_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .load (div_load),
        .num  (div_num),
        .den  (div_den),
        .fin  (div_fin),
        .quo  (div_quo)
    );

    assign unused_quo_bits = ^div_quo;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        div_load = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (ref_freq_i == '0) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end else begin
                        d.err    = 1'b0;
                        d.mode   = calc_mode_e'(rev_mode_i);
                        d.k_pend = ksel;
                        d.st     = ST_RUN;
                        div_load = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (div_fin) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    if (q.mode == MODE_FWD) begin
                        d.word = div_quo[WORD_W-1:0];
                        d.code = q.k_pend;
                    end else begin
                        d.rate = div_quo[RATE_W-1:0];
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o  = q.done;
    assign error_o = q.err;
    assign word_o  = q.word;
    assign code_o  = q.code;
    assign rate_o  = q.rate;

    // R2: a request at or below the ceiling passes the clamp untouched
    assert_clamp_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (64'(freq_req_i) <= FMAX_HZ) |-> (fclamp == freq_req_i));

    // R3: the chosen exponent is the smallest that reaches the VCO floor
    assert_k_minimal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !rev_mode_i && ksel != '0)
            |-> ((64'(fclamp) << (int'(ksel) - 1)) < FMIN_HZ));

    // R8: a zero reference completes at once with the error flag
    assert_zero_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ref_freq_i == '0) |=> (done_o && error_o));

    // R9: done lasts a single cycle unless a new zero-reference start follows
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    // R9: results only move together with done
    assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(word_o) && $stable(code_o)));

    assert_rate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rate_o));

endmodule

// File: tb/pll_word_calc_test.sv
module pll_word_calc_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int    FW     = 16;
    localparam int    WW     = 12;
    localparam int    IB     = 7;
    localparam int    FRAC   = WW - IB;
    localparam int    RW     = FW + IB + 1;
    localparam longint FMIN  = 1000;
    localparam longint FMAX  = 3000;
    localparam int    DIVW_A = FW + 4 + FRAC;
    localparam int    DIVW_B = FW + IB + 2;
    localparam int    DIVW   = (DIVW_A > DIVW_B) ? DIVW_A : DIVW_B;
    localparam int    LAT_OK = DIVW + 2;   // falling edges counted from the start edge

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rev = 1'b0;
    logic [FW-1:0] freq = '0;
    logic [FW-1:0] refr = '0;
    logic [WW-1:0] wrd = '0;
    logic [2:0]    cod = '0;
    logic          done;
    logic          err;
    logic [WW-1:0] word_o;
    logic [2:0]    code_o;
    logic [RW-1:0] rate_o;

    int n_total = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    pll_word_calc #(
        .FREQ_W  (FW),
        .WORD_W  (WW),
        .INT_BITS(IB),
        .FMIN_HZ (64'(FMIN)),
        .FMAX_HZ (64'(FMAX))
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .rev_mode_i(rev),
        .freq_req_i(freq),
        .ref_freq_i(refr),
        .word_i    (wrd),
        .code_i    (cod),
        .done_o    (done),
        .error_o   (err),
        .word_o    (word_o),
        .code_o    (code_o),
        .rate_o    (rate_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clampf(longint f);
        return (f > FMAX) ? FMAX : f;
    endfunction

    function automatic longint exp_k(longint f);
        longint fc = clampf(f);
        for (int k = 0; k <= 4; k++) if ((fc << k) >= FMIN) return k;
        return 4;
    endfunction

    function automatic longint exp_word(longint f, longint r);
        longint fc = clampf(f);
        longint k  = exp_k(f);
        return (((fc << k) << FRAC) / r) & ((64'd1 << WW) - 1);
    endfunction

    function automatic longint exp_rate(longint r, longint w, longint c);
        longint v  = r * w;
        longint vi = (v >> FRAC) + (((v & ((64'd1 << FRAC) - 1)) != 0) ? 1 : 0);
        longint pd = 64'd1 << c;
        return (vi + pd - 1) / pd;
    endfunction

    task automatic do_op(input bit m, input longint f, input longint r,
                         input longint w, input longint c, output int lat);
        @(negedge clk);
        rev = m; freq = FW'(f); refr = FW'(r); wrd = WW'(w); cod = 3'(c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic fwd_check(input longint f, input longint r);
        int lat;
        longint rate_before = rate_o;
        do_op(1'b0, f, r, 0, 0, lat);
        chk(lat == LAT_OK, "R7 latency", lat, LAT_OK);
        chk(err == 1'b0, "R8 no error", err, 0);
        chk(code_o == 3'(exp_k(f)), "R3 code", code_o, exp_k(f));
        chk(word_o == WW'(exp_word(f, r)), "R4 R1 word", word_o, exp_word(f, r));
        chk(rate_o == RW'(rate_before), "R9 rate kept", rate_o, rate_before);
    endtask

    task automatic rev_check(input longint r, input longint w, input longint c);
        int lat;
        longint wb = word_o;
        longint cb = code_o;
        do_op(1'b1, 0, r, w, c, lat);
        chk(lat == LAT_OK, "R7 latency", lat, LAT_OK);
        chk(rate_o == RW'(exp_rate(r, w, c)), "R5 R6 rate", rate_o, exp_rate(r, w, c));
        chk(word_o == WW'(wb) && code_o == 3'(cb), "R9 word kept", word_o, wb);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        n_total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin : main
        longint fwd_refs [7] = '{1, 3, 7, 26, 100, 255, 65535};
        longint rev_refs [4] = '{1, 26, 255, 65535};
        longint edge_f  [13] = '{0, 1, 62, 63, 125, 250, 500, 999, 1000, 2999, 3000, 3001, 65535};
        int lat;
        longint keep_w, keep_c, keep_r;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(done == 0 && err == 0, "R10 flags", {done, err}, 0);
        chk(word_o == 0 && code_o == 0 && rate_o == 0, "R10 results", word_o + code_o + rate_o, 0);
        rst_n = 1'b1;

        // R2 R3 R4: clamp and exponent boundaries
        foreach (edge_f[i]) foreach (fwd_refs[j]) fwd_check(edge_f[i], fwd_refs[j]);
        // R4 R1: broad forward sweep
        for (longint f = 0; f <= 4000; f += 37) foreach (fwd_refs[j]) fwd_check(f, fwd_refs[j]);

        // R5 R6: reverse sweep over every code
        for (longint c = 0; c < 8; c++)
            foreach (rev_refs[j]) begin
                for (longint w = 0; w < 4096; w += 97) rev_check(rev_refs[j], w, c);
                rev_check(rev_refs[j], 4095, c);
            end

        // R8: zero reference flags an error and leaves results alone
        keep_w = word_o; keep_c = code_o; keep_r = rate_o;
        do_op(1'b0, 1500, 0, 0, 0, lat);
        chk(lat == 1, "R8 immediate done", lat, 1);
        chk(err == 1'b1, "R8 error set", err, 1);
        chk(word_o == WW'(keep_w) && code_o == 3'(keep_c) && rate_o == RW'(keep_r),
            "R8 results held", word_o, keep_w);
        do_op(1'b1, 0, 0, 100, 2, lat);
        chk(lat == 1 && err == 1'b1, "R8 reverse zero ref", lat, 1);
        chk(rate_o == RW'(keep_r), "R8 rate held", rate_o, keep_r);
        fwd_check(1234, 26);
        chk(err == 1'b0, "R8 error cleared", err, 0);

        // R9: done is a pulse and results stay put afterwards
        keep_w = word_o; keep_c = code_o;
        @(negedge clk);
        chk(done == 1'b0, "R9 done pulse", done, 0);
        repeat (5) @(negedge clk);
        chk(word_o == WW'(keep_w) && code_o == 3'(keep_c), "R9 hold", word_o, keep_w);

        // R7: a start during a run is ignored
        @(negedge clk);
        rev = 1'b0; freq = FW'(700); refr = FW'(26); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (4) begin @(negedge clk); lat++; end
        rev = 1'b1; freq = FW'(2900); refr = FW'(3); wrd = WW'(5); cod = 3'd1; start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        chk(lat == LAT_OK, "R7 busy latency", lat, LAT_OK);
        chk(word_o == WW'(exp_word(700, 26)), "R7 busy word", word_o, exp_word(700, 26));
        chk(code_o == 3'(exp_k(700)), "R7 busy code", code_o, exp_k(700));

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule